// File: doc/BRIEF.md
# Edge-Triggered Compare-Match Timer

An 8-bit up-counter paced by a synchronous prescaler, with a compare register and an external trigger pin. In free-running mode the counter advances on every prescaler tick. When clear-on-match is enabled, it wraps to zero when it reaches the compare value.

In trigger mode the counter is held until a chosen edge appears on the synchronized trigger pin. It then counts up to the compare value, clears, and halts again. This makes a hardware-retriggerable one-shot whose length is set by the compare value and the prescaler.

Software sets the mode, the edge and the rate through four byte-wide registers on a simple write/read bus. A separate low-power reset input returns the control register to its reset value without disturbing the rest of the state.

Top module: `trig_cmp_timer`

## Requirements
- R1: The control register (address 0) reads 1 in bits 7, 6, 5 and 1 whatever value is written to it. Bits 4:3 hold the edge selection, bit 2 holds the trigger enable and bit 0 holds the low clock-select bit, and each of these reads back as written.
- R2: After `rst_n` is low, and one cycle after `lp_rst` is high, the control register reads 0xE2. The trigger is then off and the counter is free-running.
- R3: The edge selection in control bits 4:3 works as follows: 00 gives no start event, 01 starts on rising edges, 10 starts on falling edges and 11 starts on both.
- R4: With the trigger enable at 0, `active_o` stays 1, the trigger pin has no effect, and the counter keeps counting after a compare-match clear.
- R5: A control write with bit 2 set drops `active_o` from the next cycle, and the count holds its value.
- R6: In trigger mode a selected edge on `trig_pin` raises `active_o` at the third rising clock edge after the pin changes. While `active_o` is 0, the count never changes.
- R7: In trigger mode a compare-match clear sets the count to 0 and drops `active_o`. The count stays at 0 until the next selected edge.
- R8: The auxiliary register (address 1) holds clear-on-match in bit 1 and a sticky match flag in bit 7. When clear-on-match is 1 and a count tick finds the count equal to the compare register (address 2, reset 0xFF), the count returns to 0 and the flag sets. Writing 1 to bit 7 clears the flag, and writing 0 to it leaves the flag unchanged.
- R9: The clock select is {auxiliary bit 0, control bit 0}. Its values 0, 1, 2 and 3 advance the count (address 3, read-only) once every 2, 8, 32 and 128 clock cycles.
- R10: A trigger edge that arrives while the counter is running neither restarts nor resets it. In both-edges mode each edge of a stopped counter gives exactly one start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_rst | input | 1 | Synchronous reload of the control register to its reset value |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 auxiliary, 2 compare, 3 count |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| trig_pin | input | 1 | Asynchronous external trigger |
| count_o | output | 8 | Current count |
| active_o | output | 1 | Counter is allowed to advance on prescaler ticks |

## Verification
The count is measured over windows of fixed length at each of the four rates. Exact tick counts tell a wrong divider apart from a correct one.

The one-shot is started by each edge selection in turn:
- A rise in rising mode and a fall in falling mode. Each is paired with the opposite edge, which must not start the counter.
- Both directions while the selection is 00, where neither may start it.
- Both directions in both-edges mode, including edges that arrive mid-run, which must not disturb it.

The start is timed to the exact cycle to expose a wrong synchronizer depth. The end state separates a stop on match from a wrap that keeps running. A free-running pass with a small compare value and a toggling pin shows that the pin is ignored and that counting continues after the clear.

// File: rtl/trig_tmr_pkg.sv
package trig_tmr_pkg;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   typedef struct packed {
      edge_sel_e edge_sel;
      logic      trig_en;
      logic      cks_lo;
   } ctrl_t;

   typedef struct packed {
      logic cks_hi;
      logic clr_on_match;
   } aux_t;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_AUX  = 2'd1;
   localparam logic [1:0] ADDR_CMP  = 2'd2;
   localparam logic [1:0] ADDR_CNT  = 2'd3;

   localparam logic [7:0] CTRL_FIXED_ONES = 8'hE2;
   localparam int         CTRL_EDGE_LSB   = 3;
   localparam int         CTRL_TRIG_BIT   = 2;
   localparam int         CTRL_CKS_BIT    = 0;
   localparam int         AUX_CKS_BIT     = 0;
   localparam int         AUX_CLR_BIT     = 1;
   localparam int         AUX_FLAG_BIT    = 7;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int NUM_SEL = 1 << SEL_W;
   localparam int PRE_W   = 2 * (NUM_SEL - 1) + 1;

   if (SEL_W < 1) begin : g_bad_sel
      $error("tmr_prescaler: SEL_W must be at least 1");
   end

   logic [PRE_W-1:0]   pre_q;
   logic [NUM_SEL-1:0] tick_opt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + PRE_W'(1);
   end

   // Option g divides by 2^(2g+1): it fires when the low 2g+1 bits are all ones
   for (genvar g = 0; g < NUM_SEL; g++) begin : g_opt
      assign tick_opt[g] = &pre_q[2*g:0];
   end

   assign tick = tick_opt[sel];

endmodule

// File: rtl/tmr_trig_detect.sv
module tmr_trig_detect
   import trig_tmr_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin,
   input  edge_sel_e edge_sel,
   output logic      start_evt
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tmr_trig_detect: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
   assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;

   always_comb begin
      unique case (edge_sel)
         EDGE_RISE: start_evt = rise;
         EDGE_FALL: start_evt = fall;
         EDGE_BOTH: start_evt = rise | fall;
         default:   start_evt = 1'b0;
      endcase
   end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import trig_tmr_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lp_rst,
   input  logic          wr_en,
   input  logic [1:0]    addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic [DW-1:0] cnt_val,
   input  logic          match_set,
   output ctrl_t         ctrl_o,
   output aux_t          aux_o,
   output logic [DW-1:0] cmp_o,
   output logic          flag_o,
   output logic          ctrl_wr_o,
   output logic          stop_wr_o,
   output logic [DW-1:0] ctrl_rd_o
);
   if (DW != 8) begin : g_bad_dw
      $error("tmr_regs: register layout needs DW == 8");
   end

   ctrl_t         ctrl_q;
   aux_t          aux_q;
   logic [DW-1:0] cmp_q;
   logic          flag_q;
   logic          aux_wr, cmp_wr;

   assign ctrl_wr_o = wr_en && (addr == ADDR_CTRL);
   assign aux_wr    = wr_en && (addr == ADDR_AUX);
   assign cmp_wr    = wr_en && (addr == ADDR_CMP);
   assign stop_wr_o = ctrl_wr_o && wdata[CTRL_TRIG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (lp_rst) begin
         ctrl_q <= '0;
      end else if (ctrl_wr_o) begin
         ctrl_q.edge_sel <= edge_sel_e'(wdata[CTRL_EDGE_LSB +: 2]);
         ctrl_q.trig_en  <= wdata[CTRL_TRIG_BIT];
         ctrl_q.cks_lo   <= wdata[CTRL_CKS_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aux_q <= '0;
         cmp_q <= '1;
      end else begin
         if (aux_wr) begin
            aux_q.cks_hi       <= wdata[AUX_CKS_BIT];
            aux_q.clr_on_match <= wdata[AUX_CLR_BIT];
         end
         if (cmp_wr) cmp_q <= wdata;
      end
   end

   // Sticky flag: a new match outranks a write-one clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               flag_q <= 1'b0;
      else if (match_set)                       flag_q <= 1'b1;
      else if (aux_wr && wdata[AUX_FLAG_BIT])   flag_q <= 1'b0;
   end

   always_comb begin
      ctrl_rd_o = CTRL_FIXED_ONES;
      ctrl_rd_o[CTRL_EDGE_LSB +: 2] = ctrl_q.edge_sel;
      ctrl_rd_o[CTRL_TRIG_BIT]      = ctrl_q.trig_en;
      ctrl_rd_o[CTRL_CKS_BIT]       = ctrl_q.cks_lo;
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         ADDR_CTRL: rdata = ctrl_rd_o;
         ADDR_AUX: begin
            rdata[AUX_FLAG_BIT] = flag_q;
            rdata[AUX_CLR_BIT]  = aux_q.clr_on_match;
            rdata[AUX_CKS_BIT]  = aux_q.cks_hi;
         end
         ADDR_CMP: rdata = cmp_q;
         default:  rdata = cnt_val;
      endcase
   end

   assign ctrl_o = ctrl_q;
   assign aux_o  = aux_q;
   assign cmp_o  = cmp_q;
   assign flag_o = flag_q;

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          trig_en,
   input  logic          start_evt,
   input  logic          stop_wr,
   input  logic          clr_on_match,
   input  logic [CW-1:0] cmp,
   output logic [CW-1:0] cnt,
   output logic          active,
   output logic          match_clr
);
   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic          step;

   assign active    = trig_en ? run_q : 1'b1;
   assign step      = active && tick;
   assign match_clr = step && clr_on_match && (cnt_q == cmp);

   // Priority: software stop, then match stop, then a trigger start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        run_q <= 1'b0;
      else if (stop_wr)                  run_q <= 1'b0;
      else if (trig_en && match_clr)     run_q <= 1'b0;
      else if (trig_en && start_evt)     run_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (match_clr) cnt_q <= '0;
      else if (step)      cnt_q <= cnt_q + CW'(1);
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/trig_cmp_timer.sv
module trig_cmp_timer
   import trig_tmr_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lp_rst,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   input  logic             trig_pin,
   output logic [CNT_W-1:0] count_o,
   output logic             active_o
);
   localparam int SEL_W = 2;

   if (CNT_W != 8) begin : g_bad_cnt
      $error("trig_cmp_timer: CNT_W must match the 8-bit register bus");
   end

   ctrl_t            ctrl;
   aux_t             aux;
   logic [CNT_W-1:0] cmp_val, cnt;
   logic [7:0]       ctrl_rd;
   logic             flag, ctrl_wr, stop_wr, tick, start_evt, match_clr, active;
   logic [SEL_W-1:0] cks;

   assign cks = {aux.cks_hi, ctrl.cks_lo};

   tmr_regs #(.DW(8)) u_regs (
      .clk(clk), .rst_n(rst_n), .lp_rst(lp_rst),
      .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
      .cnt_val(cnt), .match_set(match_clr),
      .ctrl_o(ctrl), .aux_o(aux), .cmp_o(cmp_val), .flag_o(flag),
      .ctrl_wr_o(ctrl_wr), .stop_wr_o(stop_wr), .ctrl_rd_o(ctrl_rd)
   );

   tmr_prescaler #(.SEL_W(SEL_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .sel(cks), .tick(tick)
   );

   tmr_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk(clk), .rst_n(rst_n), .pin(trig_pin),
      .edge_sel(ctrl.edge_sel), .start_evt(start_evt)
   );

   tmr_counter #(.CW(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .trig_en(ctrl.trig_en),
      .start_evt(start_evt), .stop_wr(stop_wr),
      .clr_on_match(aux.clr_on_match), .cmp(cmp_val),
      .cnt(cnt), .active(active), .match_clr(match_clr)
   );

   assign count_o  = cnt;
   assign active_o = active;

endmodule

// File: rtl/trig_cmp_timer_chk.sv
module trig_cmp_timer_chk #(
   parameter int CW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          lp_rst,
   input logic          ctrl_wr,
   input logic          stop_wr,
   input logic          trig_en,
   input logic          active,
   input logic          tick,
   input logic          match_clr,
   input logic          flag,
   input logic [7:0]    ctrl_rd,
   input logic [CW-1:0] cnt
);
   p_lp_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lp_rst |=> ctrl_rd == 8'hE2);

   p_free_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_en && !ctrl_wr && !lp_rst) |=> active);

   p_write_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_wr && !lp_rst) |=> !active);

   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> $stable(cnt));

   p_match_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (match_clr && trig_en && !ctrl_wr && !lp_rst) |=> (!active && cnt == '0));

   p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      match_clr |=> flag);

   p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && tick && !match_clr) |=> cnt == CW'($past(cnt) + 1'b1));

   p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_en && active && !match_clr && !ctrl_wr && !lp_rst) |=> active);

endmodule

bind trig_cmp_timer trig_cmp_timer_chk #(.CW(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lp_rst(lp_rst), .ctrl_wr(ctrl_wr),
   .stop_wr(stop_wr), .trig_en(ctrl.trig_en), .active(active),
   .tick(tick), .match_clr(match_clr), .flag(flag),
   .ctrl_rd(ctrl_rd), .cnt(cnt)
);

// File: tb/trig_cmp_timer_tb.sv
module trig_cmp_timer_tb;
   logic       clk = 1'b0;
   logic       rst_n, lp_rst, bus_wr, trig_pin;
   logic [1:0] bus_addr;
   logic [7:0] bus_wdata, bus_rdata, count_o;
   logic       active_o;
   int         total = 0;
   int         fails = 0;

   always #4 clk = ~clk;

   trig_cmp_timer u_dut (
      .clk(clk), .rst_n(rst_n), .lp_rst(lp_rst), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .trig_pin(trig_pin), .count_o(count_o), .active_o(active_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Change the pin and check active_o after two and after three clock edges
   task automatic edge_start(input logic lvl, input string req);
      @(negedge clk);
      trig_pin = lvl;
      @(negedge clk); @(negedge clk);
      #1 chk({req, " not yet active"}, active_o, 0);
      @(negedge clk);
      #1 chk({req, " active on third edge"}, active_o, 1);
   endtask

   task automatic t_reset;
      logic [7:0] v;
      rd(2'd0, v); chk("R2 ctrl reset", v, 8'hE2);
      rd(2'd1, v); chk("R8 aux reset", v, 0);
      rd(2'd2, v); chk("R8 cmp reset", v, 8'hFF);
      chk("R4 active after reset", active_o, 1);
   endtask

   task automatic t_reserved;
      logic [7:0] v;
      wr(2'd0, 8'h00); rd(2'd0, v); chk("R1 write 00 reads", v, 8'hE2);
      wr(2'd0, 8'h19); rd(2'd0, v); chk("R1 write 19 reads", v, 8'hFB);
      wr(2'd0, 8'h00); rd(2'd0, v); chk("R1 write back", v, 8'hE2);
   endtask

   task automatic measure(input logic [7:0] c, input logic [7:0] a, input int exp);
      logic [7:0] s0, s1;
      wr(2'd0, c); wr(2'd1, a);
      wait_cyc(4);
      rd(2'd3, s0);
      repeat (255) @(negedge clk);
      rd(2'd3, s1);
      chk("R9 ticks in 256 cycles", int'(8'(s1 - s0)), exp);
   endtask

   task automatic t_prescaler;
      measure(8'hE2, 8'h00, 128);
      measure(8'hE3, 8'h00, 32);
      measure(8'hE2, 8'h01, 8);
      measure(8'hE3, 8'h01, 2);
   endtask

   task automatic t_rise_oneshot;
      logic [7:0] v, c0;
      wr(2'd0, 8'hE2); wr(2'd1, 8'h82); wr(2'd2, 8'h00);
      wait_cyc(600);
      wr(2'd0, 8'h0C);
      #1 chk("R5 stop after trigger-enable write", active_o, 0);
      wr(2'd1, 8'h82); wr(2'd2, 8'd6);
      rd(2'd3, c0); chk("R5 count parked at zero", c0, 0);
      wait_cyc(20);
      rd(2'd3, v); chk("R5 count held while stopped", v, c0);
      edge_start(1'b1, "R6 rising start");
      wait_cyc(4);
      #1 chk("R6 counting after start", (count_o != 0) ? 1 : 0, 1);
      wait_cyc(40);
      #1 chk("R7 stopped after match", active_o, 0);
      chk("R7 count cleared", count_o, 0);
      rd(2'd1, v); chk("R8 flag set", v[7], 1);
      wait_cyc(50);
      #1 chk("R7 waits for next edge", count_o, 0);
      wr(2'd1, 8'h02); rd(2'd1, v); chk("R8 write 0 keeps flag", v[7], 1);
      wr(2'd1, 8'h82); rd(2'd1, v); chk("R8 write 1 clears flag", v, 8'h02);
   endtask

   task automatic t_fall_and_none;
      wr(2'd0, 8'h14);
      edge_start(1'b0, "R3 falling start");
      wait_cyc(40);
      #1 chk("R3 falling one-shot done", active_o, 0);
      @(negedge clk) trig_pin = 1'b1;
      wait_cyc(10);
      #1 chk("R3 rise ignored in falling mode", active_o, 0);
      wr(2'd0, 8'h04);
      @(negedge clk) trig_pin = 1'b0;
      wait_cyc(10);
      #1 chk("R3 fall ignored with select 00", active_o, 0);
      @(negedge clk) trig_pin = 1'b1;
      wait_cyc(10);
      #1 chk("R3 rise ignored with select 00", active_o, 0);
   endtask

   task automatic t_both;
      logic [7:0] c1, c2;
      wr(2'd0, 8'h1D); wr(2'd1, 8'h82); wr(2'd2, 8'd100);
      edge_start(1'b0, "R10 both-edges fall start");
      wait_cyc(50);
      @(negedge clk) trig_pin = 1'b1;
      wait_cyc(20);
      rd(2'd3, c1);
      @(negedge clk) trig_pin = 1'b0;
      wait_cyc(20);
      rd(2'd3, c2);
      chk("R10 running through extra edges", active_o, 1);
      chk("R10 count not restarted", (c2 > c1) ? 1 : 0, 1);
      wait_cyc(1000);
      #1 chk("R10 single run ends", active_o, 0);
      chk("R10 count cleared", count_o, 0);
      edge_start(1'b1, "R10 both-edges rise start");
      wait_cyc(1000);
      #1 chk("R10 second run ends", active_o, 0);
   endtask

   task automatic t_free_run;
      int bad = 0, over = 0;
      logic seen3 = 1'b0, wrapped = 1'b0;
      logic [7:0] v;
      wr(2'd0, 8'hE2); wr(2'd1, 8'h82); wr(2'd2, 8'd3);
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         if (i % 7 == 0) trig_pin = ~trig_pin;
         #1;
         if (active_o !== 1'b1) bad++;
         if (count_o > 8'd3) over++;
         if (count_o == 8'd3) seen3 = 1'b1;
         if (seen3 && count_o == 8'd1) wrapped = 1'b1;
      end
      chk("R4 active with pin toggling", bad, 0);
      chk("R4 count bounded by compare", over, 0);
      chk("R4 keeps counting after clear", wrapped, 1);
      rd(2'd1, v); chk("R8 flag in free-run", v[7], 1);
   endtask

   task automatic t_lp_reset;
      logic [7:0] v;
      wr(2'd0, 8'h1D); rd(2'd0, v); chk("R1 all fields set", v, 8'hFF);
      @(negedge clk) lp_rst = 1'b1;
      @(negedge clk) lp_rst = 1'b0;
      rd(2'd0, v); chk("R2 lp reload", v, 8'hE2);
      chk("R2 free-running after reload", active_o, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      rst_n = 1'b0; lp_rst = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0;
      bus_wdata = 8'h00; trig_pin = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_reserved;
      t_prescaler;
      t_rise_oneshot;
      t_fall_and_none;
      t_both;
      t_free_run;
      t_lp_reset;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule